// File: doc/BRIEF.md
# Nearest-Branch Banked Branch Target Buffer

This block is a branch target buffer for a front end whose fetch addresses rarely land on a branch. A lookup may use any byte address. The block returns the closest recorded branch that sits at or after that byte, within the same 64-byte line. For that branch it also returns two targets. The first is the branch's own taken target. The second is the address the stream reached after the next branch resolved, which lets the fetch logic look two hops ahead.

An address splits into a line field (bits 31:6) and a byte offset (bits 5:0). Branches are stored in eight direct-mapped banks, indexed by the low bits of the line field. A bank holds at most one branch of any line, so a line can track up to eight branches. The banks form two clusters of four. Bit 5 of the branch offset picks the cluster: offsets 0..31 go to banks 0..3 and offsets 32..63 go to banks 4..7. Inside a cluster, the least recently recorded bank takes a new branch.

A per-line position table, with one bit per byte of the line, marks the bytes that hold recorded branches. A lookup masks this vector at the fetch offset and takes the lowest remaining bit. The bank entry at that position supplies the result, which is registered one cycle after the request.

Resolved branches arrive on the update port. A small pending-entry state machine supplies the second targets. Its states are:
- `PEND_IDLE`: no recorded branch is waiting for its second target.
- `PEND_AWAIT`: the last recorded taken branch is waiting for its second target.

Its transitions are:
- A taken update moves either state to `PEND_AWAIT`.
- A not-taken update moves either state to `PEND_IDLE`.
- In `PEND_AWAIT`, any update first writes the waiting entry's second target.

Top module: `near_btb`

## Requirements
- R1: Each lookup request produces `rsp_valid` exactly one cycle later. When there is no hit, `rsp_hit`, `rsp_off`, `rsp_target1` and `rsp_target2` are all zero.
- R2: A lookup returns the recorded branch of the requested line with the smallest offset at or after the fetch offset (address bits 5:0). An exact match counts as a hit, and `rsp_off` gives the branch's byte offset.
- R3: Recorded branches below the fetch offset are ignored. If no recorded branch of the line lies at or after the fetch offset, the lookup misses, even though the line has branches.
- R4: A lookup hits only branches whose line field (address bits 31:6) equals the fetch line. A different line that has no recorded branches misses.
- R5: A taken update records the branch with `target1` = `upd_target`. Recording a branch that is already present rewrites `target1` in place and leaves its `target2` unchanged.
- R6: A newly recorded entry has `target2` = 0. The next update after a taken branch (state `PEND_AWAIT`) writes that branch's `target2`. The value is `upd_target` if the new update is taken, or `upd_fallthru` if it is not.
- R7: A not-taken update creates no entry and returns the state to `PEND_IDLE`. A later update therefore does not change any `target2`.
- R8: Offsets 0..31 use banks 0..3 and offsets 32..63 use banks 4..7. Each cluster holds four branches of a line. A fifth branch in a cluster evicts one branch of that same cluster and never touches the other cluster.
- R9: The victim in a full cluster is the bank recorded least recently, where re-recording a branch counts as a use.
- R10: After reset every lookup misses, and the pending state is `PEND_IDLE`.
- R11: Lines that share a set index (line field modulo 16) share one position-vector slot. Recording a branch of one line makes the other line's branches miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address to look up |
| rsp_valid | output | 1 | Lookup response valid, one cycle after `lk_req` |
| rsp_hit | output | 1 | A branch was found at or after the fetch offset |
| rsp_off | output | 6 | Byte offset of the returned branch within the line |
| rsp_target1 | output | 32 | Taken target of the returned branch |
| rsp_target2 | output | 32 | Address reached after the following branch |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved branch was taken |
| upd_target | input | 32 | Taken target of the resolved branch |
| upd_fallthru | input | 32 | Fall-through address of the resolved branch |

## Verification
On every cycle, the assertions check the following:
- a response follows each request one cycle later and never appears otherwise;
- a hit never lies below the requested offset;
- at most one bank matches the selected position;
- the pending state machine moves to `PEND_AWAIT` on taken updates and to `PEND_IDLE` on not-taken updates.

Only the bench's scenarios can show which branch is the nearest, the values of the two targets, and that the bank holding a branch is the least recently recorded one. The same applies to cluster confinement and to the loss of an aliased line, because these depend on the history of updates rather than on one cycle.

// File: rtl/near_btb_pkg.sv
package near_btb_pkg;
    localparam int ADDR_W     = 32;
    localparam int OFF_W      = 6;
    localparam int LINE_W     = ADDR_W - OFF_W;
    localparam int LINE_BYTES = 1 << OFF_W;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
        logic [OFF_W-1:0]  off;
        logic [ADDR_W-1:0] t1;
        logic [ADDR_W-1:0] t2;
    } entry_t;

    typedef struct packed {
        logic                  valid;
        logic [LINE_W-1:0]     line;
        logic [LINE_BYTES-1:0] vec;
    } posvec_t;

    typedef enum logic {
        PEND_IDLE  = 1'b0,
        PEND_AWAIT = 1'b1
    } pend_state_e;
endpackage

// File: rtl/near_btb_bank.sv
module near_btb_bank
    import near_btb_pkg::*;
#(
    parameter  int SETS  = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output entry_t            lk_entry,
    input  logic [IDX_W-1:0]  pb_idx,
    output entry_t            pb_entry,
    input  logic              rec_en,
    input  logic              rec_fresh,
    input  logic [IDX_W-1:0]  rec_idx,
    input  logic [LINE_W-1:0] rec_line,
    input  logic [OFF_W-1:0]  rec_off,
    input  logic [ADDR_W-1:0] rec_t1,
    input  logic              t2_en,
    input  logic [IDX_W-1:0]  t2_idx,
    input  logic [LINE_W-1:0] t2_line,
    input  logic [OFF_W-1:0]  t2_off,
    input  logic [ADDR_W-1:0] t2_val
);
    entry_t mem [SETS];

    assign lk_entry = mem[lk_idx];
    assign pb_entry = mem[pb_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                mem[s] <= '0;
            end
        end else begin
            // second-target write lands only if the waiting branch still owns the slot
            if (t2_en && mem[t2_idx].valid && mem[t2_idx].line == t2_line
                && mem[t2_idx].off == t2_off) begin
                mem[t2_idx].t2 <= t2_val;
            end
            if (rec_en) begin
                mem[rec_idx].valid <= 1'b1;
                mem[rec_idx].line  <= rec_line;
                mem[rec_idx].off   <= rec_off;
                mem[rec_idx].t1    <= rec_t1;
                if (rec_fresh) begin
                    mem[rec_idx].t2 <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/near_btb_posvec.sv
module near_btb_posvec
    import near_btb_pkg::*;
#(
    parameter  int SETS  = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output posvec_t          lk_slot,
    input  logic [IDX_W-1:0] pb_idx,
    output posvec_t          pb_slot,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  posvec_t          wr_slot
);
    posvec_t mem [SETS];

    assign lk_slot = mem[lk_idx];
    assign pb_slot = mem[pb_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                mem[s] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_slot;
        end
    end
endmodule

// File: rtl/near_btb_lru.sv
module near_btb_lru #(
    parameter  int NUM_BANKS = 8,
    parameter  int CLUSTERS  = 2,
    parameter  int SETS      = 16,
    localparam int IDX_W     = $clog2(SETS),
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int CL_W      = $clog2(CLUSTERS),
    localparam int BPC       = NUM_BANKS / CLUSTERS,
    localparam int AGE_W     = (BPC > 1) ? $clog2(BPC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     idx,
    input  logic [CL_W-1:0]      cluster,
    input  logic [NUM_BANKS-1:0] valid_vec,
    output logic [BANK_W-1:0]    victim,
    input  logic                 touch_en,
    input  logic [BANK_W-1:0]    touch_bank
);
    logic [AGE_W-1:0] age [SETS][NUM_BANKS];

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = BANK_W'(int'(cluster) * BPC);
        for (int j = 0; j < BPC; j++) begin
            if (!found && !valid_vec[int'(cluster) * BPC + j]) begin
                victim = BANK_W'(int'(cluster) * BPC + j);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int j = 0; j < BPC; j++) begin
                if (age[idx][int'(cluster) * BPC + j] == AGE_W'(BPC - 1)) begin
                    victim = BANK_W'(int'(cluster) * BPC + j);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    age[s][b] <= AGE_W'(b % BPC);
                end
            end
        end else if (touch_en) begin
            for (int j = 0; j < BPC; j++) begin
                if ((int'(touch_bank) / BPC) * BPC + j == int'(touch_bank)) begin
                    age[idx][int'(touch_bank)] <= '0;
                end else if (age[idx][(int'(touch_bank) / BPC) * BPC + j]
                             < age[idx][int'(touch_bank)]) begin
                    age[idx][(int'(touch_bank) / BPC) * BPC + j] <=
                        age[idx][(int'(touch_bank) / BPC) * BPC + j] + AGE_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/near_btb.sv
module near_btb
    import near_btb_pkg::*;
#(
    parameter  int NUM_BANKS = 8,
    parameter  int SETS      = 16,
    parameter  int CLUSTERS  = 2,
    localparam int IDX_W     = $clog2(SETS),
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int CL_W      = $clog2(CLUSTERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [OFF_W-1:0]  rsp_off,
    output logic [ADDR_W-1:0] rsp_target1,
    output logic [ADDR_W-1:0] rsp_target2,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic [ADDR_W-1:0] upd_fallthru
);
    // ---------------- lookup side ----------------
    logic [LINE_W-1:0]     lk_line;
    logic [OFF_W-1:0]      lk_off;
    logic [IDX_W-1:0]      lk_idx;
    posvec_t               lk_slot;
    entry_t                lk_e [NUM_BANKS];
    logic [LINE_BYTES-1:0] cand;
    logic                  vec_ok;
    logic [OFF_W-1:0]      near_pos;
    logic [NUM_BANKS-1:0]  bank_sel;
    logic                  hit_d;
    logic [ADDR_W-1:0]     sel_t1, sel_t2;

    assign lk_line = lk_addr[ADDR_W-1:OFF_W];
    assign lk_off  = lk_addr[OFF_W-1:0];
    assign lk_idx  = lk_line[IDX_W-1:0];
    assign vec_ok  = lk_slot.valid && (lk_slot.line == lk_line);
    assign cand    = vec_ok ? (lk_slot.vec & ({LINE_BYTES{1'b1}} << lk_off)) : '0;

    always_comb begin
        near_pos = '0;
        for (int i = LINE_BYTES - 1; i >= 0; i--) begin
            if (cand[i]) near_pos = OFF_W'(i);
        end
    end

    always_comb begin
        sel_t1 = '0;
        sel_t2 = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_sel[b] = (|cand) && lk_e[b].valid && (lk_e[b].line == lk_line)
                          && (lk_e[b].off == near_pos);
            if (bank_sel[b]) begin
                sel_t1 = sel_t1 | lk_e[b].t1;
                sel_t2 = sel_t2 | lk_e[b].t2;
            end
        end
    end
    assign hit_d = |bank_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_off     <= '0;
            rsp_target1 <= '0;
            rsp_target2 <= '0;
        end else begin
            rsp_valid   <= lk_req;
            rsp_hit     <= lk_req && hit_d;
            rsp_off     <= (lk_req && hit_d) ? near_pos : '0;
            rsp_target1 <= (lk_req && hit_d) ? sel_t1 : '0;
            rsp_target2 <= (lk_req && hit_d) ? sel_t2 : '0;
        end
    end

    // ---------------- update side ----------------
    logic [LINE_W-1:0]     upd_line;
    logic [OFF_W-1:0]      upd_off;
    logic [IDX_W-1:0]      upd_idx;
    logic [CL_W-1:0]       upd_cluster;
    posvec_t               pb_slot;
    posvec_t               new_slot;
    entry_t                pb_e [NUM_BANKS];
    logic [NUM_BANKS-1:0]  pb_valid;
    logic [NUM_BANKS-1:0]  same_hit;
    logic                  reuse;
    logic [BANK_W-1:0]     reuse_bank, victim, tgt_bank;
    logic                  clear_old;
    logic                  rec_en;

    assign upd_line    = upd_pc[ADDR_W-1:OFF_W];
    assign upd_off     = upd_pc[OFF_W-1:0];
    assign upd_idx     = upd_line[IDX_W-1:0];
    assign upd_cluster = upd_off[OFF_W-1 -: CL_W];
    assign rec_en      = upd_valid && upd_taken;

    always_comb begin
        reuse_bank = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            pb_valid[b] = pb_e[b].valid;
            same_hit[b] = pb_e[b].valid && (pb_e[b].line == upd_line)
                          && (pb_e[b].off == upd_off);
            if (same_hit[b]) reuse_bank = BANK_W'(b);
        end
    end
    assign reuse     = |same_hit;
    assign tgt_bank  = reuse ? reuse_bank : victim;
    assign clear_old = !reuse && pb_e[victim].valid && (pb_e[victim].line == upd_line);

    always_comb begin
        new_slot.valid = 1'b1;
        new_slot.line  = upd_line;
        new_slot.vec   = (pb_slot.valid && pb_slot.line == upd_line) ? pb_slot.vec : '0;
        if (clear_old) new_slot.vec[pb_e[victim].off] = 1'b0;
        new_slot.vec[upd_off] = 1'b1;
    end

    // ---------------- pending-entry state machine ----------------
    pend_state_e       pend_state, pend_next;
    logic [BANK_W-1:0] pend_bank;
    logic [IDX_W-1:0]  pend_idx;
    logic [LINE_W-1:0] pend_line;
    logic [OFF_W-1:0]  pend_off;
    logic              t2_en;
    logic [ADDR_W-1:0] t2_val;

    always_comb begin
        pend_next = pend_state;
        unique case (pend_state)
            PEND_IDLE:  if (upd_valid && upd_taken)  pend_next = PEND_AWAIT;
            PEND_AWAIT: if (upd_valid && !upd_taken) pend_next = PEND_IDLE;
            default:    pend_next = PEND_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_state <= PEND_IDLE;
        else        pend_state <= pend_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_bank <= '0;
            pend_idx  <= '0;
            pend_line <= '0;
            pend_off  <= '0;
        end else if (rec_en) begin
            pend_bank <= tgt_bank;
            pend_idx  <= upd_idx;
            pend_line <= upd_line;
            pend_off  <= upd_off;
        end
    end

    assign t2_en  = (pend_state == PEND_AWAIT) && upd_valid;
    assign t2_val = upd_taken ? upd_target : upd_fallthru;

    // ---------------- storage ----------------
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        near_btb_bank #(.SETS(SETS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_idx   (lk_idx),
            .lk_entry (lk_e[b]),
            .pb_idx   (upd_idx),
            .pb_entry (pb_e[b]),
            .rec_en   (rec_en && (tgt_bank == BANK_W'(b))),
            .rec_fresh(!reuse),
            .rec_idx  (upd_idx),
            .rec_line (upd_line),
            .rec_off  (upd_off),
            .rec_t1   (upd_target),
            .t2_en    (t2_en && (pend_bank == BANK_W'(b))),
            .t2_idx   (pend_idx),
            .t2_line  (pend_line),
            .t2_off   (pend_off),
            .t2_val   (t2_val)
        );
    end

    near_btb_posvec #(.SETS(SETS)) u_posvec (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_idx (lk_idx),
        .lk_slot(lk_slot),
        .pb_idx (upd_idx),
        .pb_slot(pb_slot),
        .wr_en  (rec_en),
        .wr_idx (upd_idx),
        .wr_slot(new_slot)
    );

    near_btb_lru #(.NUM_BANKS(NUM_BANKS), .CLUSTERS(CLUSTERS), .SETS(SETS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (upd_idx),
        .cluster   (upd_cluster),
        .valid_vec (pb_valid),
        .victim    (victim),
        .touch_en  (rec_en),
        .touch_bank(tgt_bank)
    );
endmodule

// File: rtl/near_btb_chk.sv
module near_btb_chk
    import near_btb_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_req,
    input logic [ADDR_W-1:0]    lk_addr,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [OFF_W-1:0]     rsp_off,
    input logic                 upd_valid,
    input logic                 upd_taken,
    input pend_state_e          pend_state,
    input logic [NUM_BANKS-1:0] bank_sel
);
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    a_r1_hit_within_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    a_r3_hit_not_behind: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!rsp_hit || rsp_off >= $past(lk_addr[OFF_W-1:0])));

    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));

    a_r6_taken_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=> pend_state == PEND_AWAIT);

    a_r7_not_taken_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=> pend_state == PEND_IDLE);
endmodule

bind near_btb near_btb_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_addr   (lk_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_off   (rsp_off),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .pend_state(pend_state),
    .bank_sel  (bank_sel)
);

// File: tb/tb_near_btb.sv
module tb_near_btb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [5:0]  rsp_off;
    logic [31:0] rsp_target1, rsp_target2;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic [31:0] upd_fallthru = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    near_btb dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_off(rsp_off),
        .rsp_target1(rsp_target1), .rsp_target2(rsp_target2),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_fallthru(upd_fallthru)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] a);
        @(negedge clk);
        lk_req  = 1'b1;
        lk_addr = a;
        @(negedge clk);
        lk_req  = 1'b0;
    endtask

    task automatic update(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                          input logic [31:0] ft);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_fallthru = ft;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] a, input logic [5:0] off,
                              input logic [31:0] t1, input logic [31:0] t2);
        lookup(a);
        check(rsp_valid && rsp_hit, {tag, " hit"}, {30'd0, rsp_valid, rsp_hit}, 32'd3);
        check(rsp_off == off, {tag, " offset"}, 32'(rsp_off), 32'(off));
        check(rsp_target1 == t1, {tag, " target1"}, rsp_target1, t1);
        check(rsp_target2 == t2, {tag, " target2"}, rsp_target2, t2);
    endtask

    task automatic expect_miss(input string tag, input logic [31:0] a);
        lookup(a);
        check(rsp_valid && !rsp_hit && rsp_off == 0 && rsp_target1 == 0 && rsp_target2 == 0,
              {tag, " miss with zero outputs"}, {30'd0, rsp_valid, rsp_hit}, 32'd2);
    endtask

    // R10 / R1: reset state
    task automatic t_reset();
        check(!rsp_valid, "R10 no response after reset", 32'(rsp_valid), 0);
        expect_miss("R10 empty table", 32'h0000_1040);
        expect_miss("R1 empty table second line", 32'h0000_1080);
    endtask

    // R2 R3 R4 R5 R6 R7
    task automatic t_nearest_and_targets();
        update(32'h0000_1050, 1, 32'h0000_2000, 32'h0000_1052); // A off 0x10
        update(32'h0000_1070, 1, 32'h0000_3000, 32'h0000_1072); // B off 0x30, A.t2
        expect_hit("R2 nearest from line start", 32'h0000_1040, 6'h10, 32'h2000, 32'h3000);
        expect_hit("R2 exact offset", 32'h0000_1050, 6'h10, 32'h2000, 32'h3000);
        expect_hit("R3 skip branch behind", 32'h0000_1051, 6'h30, 32'h3000, 32'h0);
        expect_miss("R3 nothing ahead in line", 32'h0000_1071);
        expect_miss("R4 other line", 32'h0000_1080);
        update(32'h0000_5000, 0, 32'h0000_9000, 32'h0000_5004); // C not taken -> B.t2
        expect_hit("R6 fall-through to target2", 32'h0000_1060, 6'h30, 32'h3000, 32'h5004);
        expect_miss("R7 not-taken not recorded", 32'h0000_5000);
        update(32'h0000_6000, 1, 32'h0000_7000, 32'h0000_6002); // D, no pending
        expect_hit("R7 idle after not-taken keeps target2", 32'h0000_1060, 6'h30,
                   32'h3000, 32'h5004);
        expect_hit("R6 fresh entry target2 zero", 32'h0000_6000, 6'h00, 32'h7000, 32'h0);
        update(32'h0000_1050, 1, 32'h0000_2100, 32'h0000_1052); // A again, D.t2
        expect_hit("R5 rerecord target1 in place", 32'h0000_1040, 6'h10, 32'h2100, 32'h3000);
        expect_hit("R6 taken target to target2", 32'h0000_6000, 6'h00, 32'h7000, 32'h2100);
    endtask

    // R8: clusters and capacity
    task automatic t_clusters();
        for (int i = 0; i < 4; i++) update(32'h0000_00C0 + 32'(4 * i), 1, 32'h100 + 32'(i), 0);
        for (int i = 0; i < 4; i++) update(32'h0000_00E0 + 32'(4 * i), 1, 32'h200 + 32'(i), 0);
        expect_hit("R8 eight branches low", 32'h0000_00C9, 6'h0C, 32'h103, 32'h200);
        expect_hit("R8 eight branches high", 32'h0000_00E5, 6'h28, 32'h202, 32'h203);
        update(32'h0000_00D0, 1, 32'h0000_0150, 0); // fifth low-half branch
        expect_hit("R8 oldest low evicted", 32'h0000_00C0, 6'h04, 32'h101, 32'h102);
        expect_hit("R8 high cluster untouched", 32'h0000_00E0, 6'h20, 32'h200, 32'h201);
    endtask

    // R9: re-record refreshes recency
    task automatic t_lru();
        for (int i = 0; i < 4; i++) update(32'h0000_0100 + 32'(4 * i), 1, 32'h300 + 32'(i), 0);
        update(32'h0000_0100, 1, 32'h0000_0300, 0);
        update(32'h0000_0110, 1, 32'h0000_0310, 0);
        expect_hit("R9 refreshed branch kept", 32'h0000_0100, 6'h00, 32'h300, 32'h310);
        expect_hit("R9 least recent evicted", 32'h0000_0101, 6'h08, 32'h302, 32'h303);
    endtask

    // R11: set aliasing
    task automatic t_alias();
        update(32'h0000_0148, 1, 32'h0000_0400, 0);
        update(32'h0000_0548, 1, 32'h0000_0500, 0);
        expect_miss("R11 aliased line lost", 32'h0000_0140);
        expect_hit("R11 newest line present", 32'h0000_0540, 6'h08, 32'h500, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nearest_and_targets();
        t_clusters();
        t_lru();
        t_alias();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule